// File: doc/BRIEF.md
# Per-Channel Calibration Register Bank

This block holds the calibration coefficients of a two-channel converter behind a bit-serial register port. Each channel owns a 24-bit offset (zero-scale) coefficient and a 24-bit gain (full-scale) coefficient. The block also has a 16-bit read-only result register, loaded by the converter, and an 8-bit test register. A frame opens with a register code, a direction and a channel. It then carries single bits, most significant bit first, and closes with a frame-end strobe. A write takes effect only when it arrives complete, and its contents are applied at frame end in a single cycle. A read shifts out a copy of the register taken when the frame opens.

The zero-scale and full-scale coefficients of the active channel are always present at the outputs for the scaling logic. A freeze input tells the scaling logic to stop using them through a coefficient-valid flag. Freeze also blocks coefficient writes. So does a calibration-busy input.

The port is driven by a state machine with four states:
- ST_IDLE waits for `frame_start`. On a read it goes to ST_READ. On a write to the result register it goes to ST_DRAIN. On any other write it goes to ST_WRITE.
- ST_WRITE shifts bits in and returns to ST_IDLE at `frame_end`.
- ST_DRAIN counts discarded bits and returns to ST_IDLE by itself on the 16th bit.
- ST_READ shifts bits out and returns to ST_IDLE at `frame_end`.

Top module: `calreg_bank`

## Requirements
- R1: In reset, and until the first committed write, every zero-scale coefficient is 0x1F4000, every full-scale coefficient is 0x5761AB, the test register is 0x00 and the result register is 0x0000. `coef_valid` is 0 in reset.
- R2: Register codes are 3'b110 for zero-scale, 3'b111 for full-scale, 3'b011 for the result register and 3'b100 for the test register. A write frame to code 110 or 111 that carries exactly 24 bits, MSB first, stores those bits at `frame_end` into the register of the channel given at `frame_start`. The new value is visible on `zs_coef`/`fs_coef` from the cycle after `frame_end` whenever `chan` selects that channel.
- R3: A coefficient write frame carrying fewer or more than 24 bits leaves every register unchanged. Coefficient outputs change only in the cycle after a `frame_end`, or when `chan` changes.
- R4: A write frame to the result register does not change that register. It ignores `frame_end` and ends by itself after exactly 16 bits. Until then a `frame_start` has no effect.
- R5: A write frame to the test register carrying exactly 8 bits stores them. Any other count leaves it unchanged.
- R6: A coefficient write is dropped if `freeze` or `cal_busy` is high in the `frame_end` cycle.
- R7: `coef_valid` is low in the cycle after any cycle with `freeze` high, and high in the cycle after any cycle with `freeze` low.
- R8: A read frame shifts out the selected register MSB first on `bit_out`. Widths are 24 bits for coefficients, 16 for the result register and 8 for the test register. The first bit is present from the cycle after `frame_start`. Each `bit_valid` advances one bit. The bits come from a copy taken at `frame_start`, so later updates do not change them. After the last bit, and outside reads, `bit_out` is 0.
- R9: A `conv_load` pulse stores `conv_data` into the result register, which reads return.
- R10: Codes other than 011, 100, 110 and 111 have 8-bit frames. Writes to them are dropped and reads of them return zeros. A `frame_start` while a frame is open is ignored.
- R11: The two channels' coefficient pairs are independent. A write to one channel leaves the other channel's values unchanged.
- R12: If `frame_end` and `bit_valid` are high in the same cycle of a frame, the bit is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Opens a frame (accepted in ST_IDLE only) |
| rd_nwr | input | 1 | Frame direction at `frame_start`: 1 read, 0 write |
| reg_sel | input | 3 | Register code at `frame_start` |
| chan | input | 1 | Channel for access at `frame_start`; also the active channel for the coefficient outputs |
| bit_valid | input | 1 | One serial bit this cycle |
| bit_in | input | 1 | Serial write data |
| frame_end | input | 1 | Closes a write or read frame |
| bit_out | output | 1 | Serial read data |
| conv_load | input | 1 | Load strobe for a new conversion result |
| conv_data | input | 16 | New conversion result |
| freeze | input | 1 | Withdraws coefficients from scaling and blocks coefficient writes |
| cal_busy | input | 1 | Calibration in progress; blocks coefficient writes |
| zs_coef | output | 24 | Zero-scale coefficient of the active channel |
| fs_coef | output | 24 | Full-scale coefficient of the active channel |
| coef_valid | output | 1 | Coefficients may be used by scaling |

## Verification
The hardest case to reach is a result-register write whose `frame_end` arrives early. The port has to stay in ST_DRAIN, ignore both that strobe and a following `frame_start`, and still leave by itself on the 16th bit. The bench sends 8 bits and a premature `frame_end`, then tries to open a read of the test register, and only then sends the other 8 bits. The reference model must agree on every cycle that no read ever started. Snapshot isolation is reached by pulsing `conv_load` in the middle of a result-register read. Write lockout is reached by raising `freeze` or `cal_busy` only in the `frame_end` cycle of an otherwise complete 24-bit write.

// File: rtl/calreg_pkg.sv
package calreg_pkg;
    localparam int CAL_W  = 24;
    localparam int DATA_W = 16;
    localparam int TEST_W = 8;
    localparam int DFLT_W = 8;

    localparam logic [2:0] SEL_DATA = 3'b011;
    localparam logic [2:0] SEL_TEST = 3'b100;
    localparam logic [2:0] SEL_ZS   = 3'b110;
    localparam logic [2:0] SEL_FS   = 3'b111;

    typedef enum logic [1:0] {ST_IDLE, ST_WRITE, ST_DRAIN, ST_READ} port_st_t;

    // number of serial bits a frame to this code must carry
    function automatic int unsigned frame_len(input logic [2:0] code);
        unique case (code)
            SEL_ZS, SEL_FS: frame_len = CAL_W;
            SEL_DATA:       frame_len = DATA_W;
            SEL_TEST:       frame_len = TEST_W;
            default:        frame_len = DFLT_W;
        endcase
    endfunction
endpackage

// File: rtl/calreg_fsm.sv
module calreg_fsm
    import calreg_pkg::*;
#(
    parameter int CW  = 6,
    parameter int CHW = 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           frame_start,
    input  logic           rd_nwr,
    input  logic [2:0]     sel,
    input  logic [CHW-1:0] chan,
    input  logic           bit_valid,
    input  logic           frame_end,
    output port_st_t       state,
    output logic [2:0]     sel_q,
    output logic [CHW-1:0] chan_q,
    output logic           snap,
    output logic           shift_en,
    output logic           commit
);
    localparam logic [CW-1:0] DRAIN_LAST = CW'(DATA_W - 1);

    port_st_t      state_d;
    logic [CW-1:0] cnt, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            sel_q  <= '0;
            chan_q <= '0;
        end else begin
            state <= state_d;
            cnt   <= cnt_d;
            if (snap) begin
                sel_q  <= sel;
                chan_q <= chan;
            end
        end
    end

    // transitions and strobes
    always_comb begin
        state_d  = state;
        cnt_d    = cnt;
        snap     = 1'b0;
        shift_en = 1'b0;
        commit   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (frame_start) begin
                    snap  = 1'b1;
                    cnt_d = '0;
                    if (rd_nwr)                state_d = ST_READ;
                    else if (sel == SEL_DATA)  state_d = ST_DRAIN;
                    else                       state_d = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (frame_end) begin
                    commit  = (cnt == CW'(frame_len(sel_q)));
                    state_d = ST_IDLE;
                end else if (bit_valid) begin
                    shift_en = 1'b1;
                    if (cnt != '1) cnt_d = cnt + 1'b1;
                end
            end
            ST_DRAIN: begin
                if (bit_valid) begin
                    if (cnt == DRAIN_LAST) state_d = ST_IDLE;
                    else                   cnt_d   = cnt + 1'b1;
                end
            end
            ST_READ: begin
                if (frame_end)      state_d  = ST_IDLE;
                else if (bit_valid) shift_en = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/calreg_shift.sv
module calreg_shift #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift_en,
    input  logic         shift_in,
    output logic [W-1:0] sreg
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        sreg <= '0;
        else if (load)     sreg <= load_val;
        else if (shift_en) sreg <= {sreg[W-2:0], shift_in};
    end
endmodule

// File: rtl/calreg_store.sv
module calreg_store
    import calreg_pkg::*;
#(
    parameter int                NCH    = 2,
    parameter int                CHW    = 1,
    parameter logic [CAL_W-1:0]  ZS_RST = 24'h1F4000,
    parameter logic [CAL_W-1:0]  FS_RST = 24'h5761AB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [2:0]        wsel,
    input  logic [CHW-1:0]    wchan,
    input  logic [CAL_W-1:0]  wdata,
    input  logic              lock,
    input  logic              conv_load,
    input  logic [DATA_W-1:0] conv_data,
    input  logic [2:0]        rsel,
    input  logic [CHW-1:0]    rchan,
    input  logic [CHW-1:0]    act_chan,
    output logic [CAL_W-1:0]  rd_val,
    output logic [CAL_W-1:0]  zs_out,
    output logic [CAL_W-1:0]  fs_out
);
    logic [CAL_W-1:0]  zs_r [NCH];
    logic [CAL_W-1:0]  fs_r [NCH];
    logic [TEST_W-1:0] test_r;
    logic [DATA_W-1:0] data_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                zs_r[c] <= ZS_RST;
                fs_r[c] <= FS_RST;
            end
            test_r <= '0;
            data_r <= '0;
        end else begin
            for (int c = 0; c < NCH; c++) begin
                if (commit && !lock && wchan == CHW'(c)) begin
                    if (wsel == SEL_ZS) zs_r[c] <= wdata;
                    if (wsel == SEL_FS) fs_r[c] <= wdata;
                end
            end
            if (commit && wsel == SEL_TEST) test_r <= wdata[TEST_W-1:0];
            if (conv_load) data_r <= conv_data;
        end
    end

    // read value, left aligned so the MSB leaves first
    always_comb begin
        unique case (rsel)
            SEL_ZS:   rd_val = (int'(rchan) < NCH) ? zs_r[rchan] : '0;
            SEL_FS:   rd_val = (int'(rchan) < NCH) ? fs_r[rchan] : '0;
            SEL_DATA: rd_val = {data_r, {(CAL_W-DATA_W){1'b0}}};
            SEL_TEST: rd_val = {test_r, {(CAL_W-TEST_W){1'b0}}};
            default:  rd_val = '0;
        endcase
    end

    assign zs_out = (int'(act_chan) < NCH) ? zs_r[act_chan] : '0;
    assign fs_out = (int'(act_chan) < NCH) ? fs_r[act_chan] : '0;
endmodule

// File: rtl/calreg_bank.sv
module calreg_bank
    import calreg_pkg::*;
#(
    parameter int               NCH    = 2,
    parameter logic [CAL_W-1:0] ZS_RST = 24'h1F4000,
    parameter logic [CAL_W-1:0] FS_RST = 24'h5761AB,
    localparam int              CHW    = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int              CW     = $clog2(CAL_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              rd_nwr,
    input  logic [2:0]        reg_sel,
    input  logic [CHW-1:0]    chan,
    input  logic              bit_valid,
    input  logic              bit_in,
    input  logic              frame_end,
    output logic              bit_out,
    input  logic              conv_load,
    input  logic [DATA_W-1:0] conv_data,
    input  logic              freeze,
    input  logic              cal_busy,
    output logic [CAL_W-1:0]  zs_coef,
    output logic [CAL_W-1:0]  fs_coef,
    output logic              coef_valid
);
    port_st_t         state;
    logic [2:0]       sel_q;
    logic [CHW-1:0]   chan_q;
    logic             snap, shift_en, commit;
    logic [CAL_W-1:0] sreg, rd_val;

    calreg_fsm #(.CW(CW), .CHW(CHW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .rd_nwr(rd_nwr),
        .sel(reg_sel), .chan(chan), .bit_valid(bit_valid), .frame_end(frame_end),
        .state(state), .sel_q(sel_q), .chan_q(chan_q), .snap(snap),
        .shift_en(shift_en), .commit(commit)
    );

    calreg_shift #(.W(CAL_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(snap), .load_val(rd_val),
        .shift_en(shift_en), .shift_in((state == ST_READ) ? 1'b0 : bit_in),
        .sreg(sreg)
    );

    calreg_store #(.NCH(NCH), .CHW(CHW), .ZS_RST(ZS_RST), .FS_RST(FS_RST)) u_store (
        .clk(clk), .rst_n(rst_n), .commit(commit), .wsel(sel_q), .wchan(chan_q),
        .wdata(sreg), .lock(freeze | cal_busy), .conv_load(conv_load),
        .conv_data(conv_data), .rsel(reg_sel), .rchan(chan), .act_chan(chan),
        .rd_val(rd_val), .zs_out(zs_coef), .fs_out(fs_coef)
    );

    assign bit_out = (state == ST_READ) & sreg[CAL_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) coef_valid <= 1'b0;
        else        coef_valid <= !freeze;
    end
endmodule

// File: rtl/calreg_bank_chk.sv
module calreg_bank_chk
    import calreg_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        freeze,
    input logic        cal_busy,
    input logic        frame_end,
    input logic        bit_valid,
    input logic        bit_out,
    input logic [0:0]  chan,
    input logic [23:0] zs_coef,
    input logic [23:0] fs_coef,
    input logic        coef_valid,
    input port_st_t    state
);
    // R1
    rst_values_chk: assert property (@(posedge clk)
        !rst_n |=> (zs_coef == 24'h1F4000 && fs_coef == 24'h5761AB));

    // R3
    coef_only_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> (!$stable(chan) || ($stable(zs_coef) && $stable(fs_coef))));

    // R6
    locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze || cal_busy) |=> (!$stable(chan) || ($stable(zs_coef) && $stable(fs_coef))));

    // R7
    freeze_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> !coef_valid);

    // R7
    thaw_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !freeze |=> coef_valid);

    // R8
    read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ && !bit_valid && !frame_end) |=> $stable(bit_out));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_READ) |-> !bit_out);
endmodule

bind calreg_bank calreg_bank_chk u_chk (.*);

// File: tb/tb_calreg_bank.sv
module tb_calreg_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0, rd_nwr = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [0:0]  chan = '0;
    logic        bit_valid = 1'b0, bit_in = 1'b0, frame_end = 1'b0;
    logic        bit_out;
    logic        conv_load = 1'b0;
    logic [15:0] conv_data = '0;
    logic        freeze = 1'b0, cal_busy = 1'b0;
    logic [23:0] zs_coef, fs_coef;
    logic        coef_valid;

    int nchk = 0, nfail = 0;

    always #4 clk = ~clk;

    calreg_bank dut (.*);

    // ---------------- behavioural reference model ----------------
    int m_zs[2], m_fs[2], m_test, m_data;
    int m_mode;              // 0 idle, 1 write, 2 drain, 3 read
    int m_sel, m_ch, m_cnt, m_acc;
    bit m_rq[$];
    bit m_cv;

    function automatic int len_of(int s);
        if (s == 6 || s == 7) return 24;
        if (s == 3) return 16;
        return 8;
    endfunction

    function automatic int val_of(int s, int c);
        case (s)
            6: return m_zs[c];
            7: return m_fs[c];
            3: return m_data;
            4: return m_test;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_zs = '{24'h1F4000, 24'h1F4000};
            m_fs = '{24'h5761AB, 24'h5761AB};
            m_test = 0; m_data = 0; m_mode = 0; m_cv = 0;
            m_rq.delete();
        end else begin
            case (m_mode)
                0: if (frame_start) begin
                    m_sel = reg_sel; m_ch = chan; m_cnt = 0; m_acc = 0;
                    if (rd_nwr) begin
                        m_rq.delete();
                        for (int i = len_of(m_sel) - 1; i >= 0; i--)
                            m_rq.push_back(bit'((val_of(m_sel, m_ch) >> i) & 1));
                        m_mode = 3;
                    end else m_mode = (m_sel == 3) ? 2 : 1;
                end
                1: if (frame_end) begin
                    if (m_cnt == len_of(m_sel)) begin
                        if (m_sel == 4) m_test = m_acc & 8'hFF;
                        if (!freeze && !cal_busy) begin
                            if (m_sel == 6) m_zs[m_ch] = m_acc & 24'hFFFFFF;
                            if (m_sel == 7) m_fs[m_ch] = m_acc & 24'hFFFFFF;
                        end
                    end
                    m_mode = 0;
                end else if (bit_valid) begin
                    m_acc = (m_acc << 1) | int'(bit_in);
                    m_cnt++;
                end
                2: if (bit_valid) begin
                    m_cnt++;
                    if (m_cnt == 16) m_mode = 0;
                end
                3: if (frame_end) m_mode = 0;
                   else if (bit_valid && m_rq.size() > 0) void'(m_rq.pop_front());
                default: m_mode = 0;
            endcase
            if (conv_load) m_data = conv_data;
            m_cv = !freeze;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) if (rst_n) begin
        chk(zs_coef == 24'(m_zs[chan]), "R2 zs_coef vs model", zs_coef, m_zs[chan]);
        chk(fs_coef == 24'(m_fs[chan]), "R2 fs_coef vs model", fs_coef, m_fs[chan]);
        chk(coef_valid == m_cv, "R7 coef_valid vs model", coef_valid, m_cv);
        chk(bit_out == ((m_mode == 3 && m_rq.size() > 0) ? m_rq[0] : 1'b0),
            "R8 bit_out vs model", bit_out, (m_mode == 3 && m_rq.size() > 0) ? m_rq[0] : 0);
    end

    // ---------------- stimulus ----------------
    task automatic tick; @(posedge clk); #2; endtask

    task automatic start(input logic [2:0] s, input logic rd, input logic c);
        frame_start = 1'b1; reg_sel = s; rd_nwr = rd; chan = c;
        tick;
        frame_start = 1'b0;
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            bit_valid = 1'b1; bit_in = v[i];
            tick;
        end
        bit_valid = 1'b0; bit_in = 1'b0;
    endtask

    task automatic end_frame; frame_end = 1'b1; tick; frame_end = 1'b0; endtask

    task automatic write_reg(input logic [2:0] s, input logic c, input logic [31:0] v, input int n);
        start(s, 1'b0, c); send_bits(v, n); end_frame;
    endtask

    task automatic read_reg(input logic [2:0] s, input logic c, input int n, output logic [23:0] v);
        start(s, 1'b1, c);
        v = '0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk); v = {v[22:0], bit_out};
            bit_valid = 1'b1; tick; bit_valid = 1'b0;
        end
        end_frame;
    endtask

    logic [23:0] rv;

    initial begin
        repeat (3) tick;
        // R1 reset state
        chk(zs_coef == 24'h1F4000, "R1 zs reset", zs_coef, 24'h1F4000);
        chk(fs_coef == 24'h5761AB, "R1 fs reset", fs_coef, 24'h5761AB);
        chk(coef_valid == 1'b0, "R1 coef_valid in reset", coef_valid, 0);
        rst_n = 1'b1;
        tick; tick;
        read_reg(3'b100, 0, 8, rv);
        chk(rv[7:0] == 8'h00, "R1 test reset", rv, 0);
        read_reg(3'b111, 1, 24, rv);
        chk(rv == 24'h5761AB, "R1 ch1 fs reset read", rv, 24'h5761AB);

        // R2 full 24-bit writes
        write_reg(3'b110, 0, 24'hABCDEF, 24);
        chan = 0; tick;
        chk(zs_coef == 24'hABCDEF, "R2 zs ch0 write", zs_coef, 24'hABCDEF);
        write_reg(3'b111, 1, 24'h123456, 24);
        chan = 1; tick;
        chk(fs_coef == 24'h123456, "R2 fs ch1 write", fs_coef, 24'h123456);
        // R11 other channel untouched
        chk(zs_coef == 24'h1F4000, "R11 ch1 zs untouched", zs_coef, 24'h1F4000);
        chan = 0; tick;
        chk(fs_coef == 24'h5761AB, "R11 ch0 fs untouched", fs_coef, 24'h5761AB);

        // R3 short and long frames
        write_reg(3'b110, 0, 24'h111111, 23);
        chk(zs_coef == 24'hABCDEF, "R3 23-bit write dropped", zs_coef, 24'hABCDEF);
        write_reg(3'b110, 0, 32'h1222222, 25);
        chk(zs_coef == 24'hABCDEF, "R3 25-bit write dropped", zs_coef, 24'hABCDEF);

        // R12 frame_end with a bit in the same cycle: bit not taken -> 23 bits
        start(3'b110, 1'b0, 0); send_bits(24'h333333, 23);
        bit_valid = 1'b1; bit_in = 1'b1; frame_end = 1'b1; tick;
        bit_valid = 1'b0; frame_end = 1'b0; bit_in = 1'b0;
        chk(zs_coef == 24'hABCDEF, "R12 coincident bit dropped", zs_coef, 24'hABCDEF);

        // R6/R7 lockout at frame end
        start(3'b110, 1'b0, 0); send_bits(24'h444444, 24);
        freeze = 1'b1; end_frame;
        chk(coef_valid == 1'b0, "R7 coef_valid low under freeze", coef_valid, 0);
        freeze = 1'b0; tick;
        chk(zs_coef == 24'hABCDEF, "R6 freeze blocks write", zs_coef, 24'hABCDEF);
        chk(coef_valid == 1'b1, "R7 coef_valid back", coef_valid, 1);
        start(3'b111, 1'b0, 0); send_bits(24'h555555, 24);
        cal_busy = 1'b1; end_frame; cal_busy = 1'b0;
        chk(fs_coef == 24'h5761AB, "R6 cal_busy blocks write", fs_coef, 24'h5761AB);

        // R9 conversion result
        conv_data = 16'hBEEF; conv_load = 1'b1; tick; conv_load = 1'b0;
        // R4 result-register write: early frame_end and frame_start ignored
        start(3'b011, 1'b0, 0);
        send_bits(8'hFF, 8);
        end_frame;
        start(3'b100, 1'b1, 0);
        send_bits(8'h00, 8);
        tick;
        chk(bit_out == 1'b0, "R4 no read opened during drain", bit_out, 0);
        read_reg(3'b011, 0, 16, rv);
        chk(rv[15:0] == 16'hBEEF, "R4 R9 result kept and readable", rv, 16'hBEEF);

        // R5 test register
        write_reg(3'b100, 0, 8'h5A, 8);
        read_reg(3'b100, 0, 8, rv);
        chk(rv[7:0] == 8'h5A, "R5 test write", rv, 8'h5A);
        write_reg(3'b100, 0, 8'h0F, 7);
        read_reg(3'b100, 0, 8, rv);
        chk(rv[7:0] == 8'h5A, "R5 short test write dropped", rv, 8'h5A);

        // R8 snapshot isolation
        start(3'b011, 1'b1, 0);
        rv = '0;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk); rv = {rv[22:0], bit_out};
            bit_valid = 1'b1;
            if (i == 4) begin conv_data = 16'h1234; conv_load = 1'b1; end
            tick; bit_valid = 1'b0; conv_load = 1'b0;
        end
        end_frame;
        chk(rv[15:0] == 16'hBEEF, "R8 snapshot unaffected by load", rv, 16'hBEEF);
        read_reg(3'b011, 0, 16, rv);
        chk(rv[15:0] == 16'h1234, "R9 new result", rv, 16'h1234);

        // R10 unknown code and frame_start during read
        write_reg(3'b000, 0, 8'hFF, 8);
        read_reg(3'b000, 0, 8, rv);
        chk(rv[7:0] == 8'h00, "R10 unknown code reads zero", rv, 0);
        start(3'b110, 1'b1, 0);
        start(3'b100, 1'b1, 0);
        rv = '0;
        for (int i = 0; i < 24; i++) begin
            @(negedge clk); rv = {rv[22:0], bit_out};
            bit_valid = 1'b1; tick; bit_valid = 1'b0;
        end
        end_frame;
        chk(rv == 24'hABCDEF, "R10 second frame_start ignored", rv, 24'hABCDEF);

        repeat (4) tick;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule